// File: doc/BRIEF.md
# Per-Pixel Top-Three Baseline Estimator

This block watches a stream of pixel samples, each tagged with the index of the pixel location it belongs to, and keeps for every location the three largest samples seen in the current window. A window spans a fixed number of frames. When the window closes, the block walks every location in ascending index order and emits one baseline per cycle. Each baseline is a weighted mean of that location's three largest samples. A later stage uses these baselines to normalize the pixels.

Each location's record lives in an on-chip memory indexed by pixel. Every accepted sample costs one read and one write-back, both pipelined. The record written in one cycle is forwarded into the next cycle, so back-to-back samples for the same location each count. The readout also clears each record as it goes. A sweep after reset zeroes all records before the first window, so the memory needs no reset.

The frame size, sample width and window length are parameters. A 100 by 100 frame with 8-bit samples is one intended setting.

Top module: `pixbase_top`

## Requirements
- R1: After reset, `out_valid` is low. For the first NPIX cycles after the internal reset release, the block clears every record, and samples presented in that time are ignored.
- R2: For each location, the block keeps the three largest samples accepted in the current window, separately from every other location. Samples may arrive in any index order.
- R3: With the kept samples a >= b >= c, the baseline equals (2a + b + c + 2) >> 2, which is the weighted mean rounded to nearest with halves rounded up. A full-scale input gives a full-scale result.
- R4: Equal samples each take their own slot. For example, 250, 250 and 10 give 190, and three samples of 200 give 200.
- R5: Samples for the same location on consecutive cycles are all counted.
- R6: A window ends when the sample at index NPIX-1 is accepted for the FRAMES-th time. Starting two cycles later, the block emits NPIX results on consecutive cycles with `out_idx` running 0, 1, ..., NPIX-1.
- R7: `in_valid` has no effect during the NPIX cycles of the readout.
- R8: Readout clears every record, so the next window's baselines depend only on that window's samples.
- R9: `out_valid` is high only during a readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_pix | input | IDX_W | Pixel location of the sample |
| in_sample | input | SW | Sample value, unsigned |
| out_valid | output | 1 | Baseline present this cycle |
| out_idx | output | IDX_W | Location of the baseline |
| out_base | output | SW | Baseline value |

## Verification
The bench builds the block with a 4 by 2 frame, 8-bit samples and a five-frame window. With these values, three complete windows with their readouts fit in a few hundred cycles. The last index, 7, ends every frame. Each record is reused twice, which exposes any record that is not cleared. Within those windows, the bench sends bursts of samples for one location on consecutive cycles, places ties and full-scale values, and drives junk input both during the clearing sweep and during every readout.

// File: rtl/pixbase_pkg.sv
package pixbase_pkg;
  typedef enum logic [1:0] {
    PB_INIT  = 2'd0,
    PB_ACCUM = 2'd1,
    PB_DRAIN = 2'd2
  } pb_mode_e;

  localparam int unsigned PB_SLOTS = 3;
endpackage

// File: rtl/pixbase_rank.sv
// Inserts one sample into a descending three-slot record; ties keep the
// resident value ahead of the newcomer.
module pixbase_rank
  import pixbase_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic [SW-1:0]               smp,
  input  logic [PB_SLOTS-1:0][SW-1:0] cur,
  output logic [PB_SLOTS-1:0][SW-1:0] nxt
);
  logic [PB_SLOTS-1:0] beats;

  for (genvar j = 0; j < PB_SLOTS; j++) begin : g_slot
    assign beats[j] = smp > cur[j];
    if (j == 0) begin : g_top
      assign nxt[j] = beats[j] ? smp : cur[j];
    end else begin : g_rest
      assign nxt[j] = !beats[j]    ? cur[j]   :
                      beats[j-1]   ? cur[j-1] : smp;
    end
  end
endmodule

// File: rtl/pixbase_mean.sv
// Weighted mean of the three slots with rounding to nearest.
module pixbase_mean
  import pixbase_pkg::*;
#(
  parameter int SW    = 8,
  parameter int W0    = 2,
  parameter int W1    = 1,
  parameter int W2    = 1,
  parameter int SHIFT = 2
) (
  input  logic [PB_SLOTS-1:0][SW-1:0] rec,
  output logic [SW-1:0]               base
);
  localparam int ACC_W = SW + SHIFT + 2;
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (SHIFT - 1);

  logic [ACC_W-1:0] acc;

  always_comb begin
    acc = ACC_W'(W0) * ACC_W'(rec[0])
        + ACC_W'(W1) * ACC_W'(rec[1])
        + ACC_W'(W2) * ACC_W'(rec[2])
        + HALF;
  end

  assign base = acc[SHIFT +: SW];
endmodule

// File: rtl/pixbase_store.sv
// Per-location record memory: one registered read port, one write port.
module pixbase_store #(
  parameter int DEPTH = 1000,
  parameter int AW    = 10,
  parameter int DW    = 24
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/pixbase_top.sv
module pixbase_top
  import pixbase_pkg::*;
#(
  parameter  int COLS   = 40,
  parameter  int ROWS   = 25,
  parameter  int SW     = 8,
  parameter  int FRAMES = 1024,
  localparam int NPIX   = COLS * ROWS,
  localparam int IDX_W  = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_pix,
  input  logic [SW-1:0]    in_sample,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx,
  output logic [SW-1:0]    out_base
);
  localparam int FW = $clog2(FRAMES + 1);
  localparam int DW = PB_SLOTS * SW;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPIX - 1);
  localparam logic [FW-1:0]    LAST_FRM = FW'(FRAMES - 1);

  typedef logic [PB_SLOTS-1:0][SW-1:0] rec_t;

  // reset synchronizer: asserts asynchronously, releases on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // control state
  pb_mode_e         mode_q, mode_n;
  logic [IDX_W-1:0] cnt_q, cnt_n;
  logic [FW-1:0]    frm_q, frm_n;

  // stage 1 (record read back)
  logic             s1_vld_q, s1_vld_n;
  logic             s1_drain_q, s1_drain_n;
  logic [IDX_W-1:0] s1_pix_q, s1_pix_n;
  logic [SW-1:0]    s1_smp_q;

  // forwarding of the last write
  logic             wr_vld_q;
  logic [IDX_W-1:0] wr_pix_q;
  rec_t             wr_rec_q;

  // output registers
  logic             ov_q, ov_n;
  logic [IDX_W-1:0] oidx_q;
  logic [SW-1:0]    obase_q;

  logic             take, last_pix, win_done, cnt_last;
  logic             rd_en, wr_en;
  logic [IDX_W-1:0] rd_addr, wr_addr;
  logic [DW-1:0]    rd_data;
  rec_t             cur_rec, upd_rec, wr_rec;
  logic [SW-1:0]    base;

  // next-state logic
  always_comb begin
    take     = in_valid && (mode_q == PB_ACCUM);
    last_pix = (in_pix == LAST_IDX);
    win_done = take && last_pix && (frm_q == LAST_FRM);
    cnt_last = (cnt_q == LAST_IDX);

    mode_n = mode_q;
    cnt_n  = cnt_q;
    frm_n  = frm_q;
    unique case (mode_q)
      PB_INIT: begin
        cnt_n = cnt_last ? '0 : cnt_q + 1'b1;
        if (cnt_last) mode_n = PB_ACCUM;
      end
      PB_ACCUM: begin
        if (take && last_pix) frm_n = win_done ? '0 : frm_q + 1'b1;
        if (win_done) begin
          mode_n = PB_DRAIN;
          cnt_n  = '0;
        end
      end
      PB_DRAIN: begin
        cnt_n = cnt_last ? '0 : cnt_q + 1'b1;
        if (cnt_last) mode_n = PB_ACCUM;
      end
      default: mode_n = PB_INIT;
    endcase

    rd_en   = take || (mode_q == PB_DRAIN);
    rd_addr = (mode_q == PB_DRAIN) ? cnt_q : in_pix;

    s1_vld_n   = rd_en;
    s1_drain_n = (mode_q == PB_DRAIN);
    s1_pix_n   = rd_addr;
  end

  // stage 1 datapath
  always_comb begin
    cur_rec = (wr_vld_q && (wr_pix_q == s1_pix_q)) ? wr_rec_q : rec_t'(rd_data);
    wr_en   = s1_vld_q || (mode_q == PB_INIT);
    wr_addr = s1_vld_q ? s1_pix_q : cnt_q;
    wr_rec  = (s1_vld_q && !s1_drain_q) ? upd_rec : '0;
    ov_n    = s1_vld_q && s1_drain_q;
  end

  pixbase_rank #(.SW(SW)) u_rank (
    .smp (s1_smp_q),
    .cur (cur_rec),
    .nxt (upd_rec)
  );

  pixbase_mean #(.SW(SW)) u_mean (
    .rec  (cur_rec),
    .base (base)
  );

  pixbase_store #(.DEPTH(NPIX), .AW(IDX_W), .DW(DW)) u_store (
    .clk     (clk),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (DW'(wr_rec))
  );

  // control registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      mode_q     <= PB_INIT;
      cnt_q      <= '0;
      frm_q      <= '0;
      s1_vld_q   <= 1'b0;
      s1_drain_q <= 1'b0;
      wr_vld_q   <= 1'b0;
      ov_q       <= 1'b0;
    end else begin
      mode_q     <= mode_n;
      cnt_q      <= cnt_n;
      frm_q      <= frm_n;
      s1_vld_q   <= s1_vld_n;
      s1_drain_q <= s1_drain_n;
      wr_vld_q   <= wr_en;
      ov_q       <= ov_n;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (s1_vld_n) begin
      s1_pix_q <= s1_pix_n;
      s1_smp_q <= in_sample;
    end
    if (wr_en) begin
      wr_pix_q <= wr_addr;
      wr_rec_q <= wr_rec;
    end
    if (ov_n) begin
      oidx_q  <= s1_pix_q;
      obase_q <= base;
    end
  end

  assign out_valid = ov_q;
  assign out_idx   = oidx_q;
  assign out_base  = obase_q;
endmodule

// File: rtl/pixbase_chk.sv
module pixbase_chk
  import pixbase_pkg::*;
#(
  parameter int NPIX  = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic [IDX_W-1:0] out_idx,
  input pb_mode_e         mode
);
  localparam int RW = $clog2(NPIX + 2);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (out_valid) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  // R6: indices stay inside the frame
  a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_idx <= IDX_W'(NPIX - 1)));

  // R6: a readout starts at location zero
  a_r6_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_idx == '0));

  // R6: consecutive results step by one
  a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_idx == $past(out_idx) + 1'b1));

  // R6: each readout burst covers every location exactly once
  a_r6_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (run_q == RW'(NPIX)));

  // R9: no results while the clearing sweep runs
  a_r9_quiet_init: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PB_INIT) |-> !out_valid);
endmodule

bind pixbase_top pixbase_chk #(.NPIX(NPIX), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_idx   (out_idx),
  .mode      (mode_q)
);

// File: tb/tb_pixbase_top.sv
`timescale 1ns/1ps
module tb_pixbase_top;
  localparam int COLS = 4;
  localparam int ROWS = 2;
  localparam int NPIX = COLS * ROWS;
  localparam int IW   = 3;
  localparam int FR   = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [IW-1:0] in_pix;
  logic [7:0]    in_sample;
  logic          out_valid;
  logic [IW-1:0] out_idx;
  logic [7:0]    out_base;

  always #2 clk = ~clk;

  pixbase_top #(.COLS(COLS), .ROWS(ROWS), .SW(8), .FRAMES(FR)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .in_sample(in_sample), .out_valid(out_valid), .out_idx(out_idx),
    .out_base(out_base)
  );

  int    nchk = 0;
  int    nfail = 0;
  int    cyc = 0;
  int    last_out_cyc = -10;
  bit    done = 1'b0;
  int    hist [NPIX][$];
  int    exp_idx [$];
  int    exp_base [$];
  string exp_req [$];

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic check(bit ok, string req, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic put(int p, int v);
    @(negedge clk);
    in_valid = 1'b1; in_pix = IW'(p); in_sample = 8'(v);
    hist[p].push_back(v);
  endtask

  task automatic junk(int p, int v);
    @(negedge clk);
    in_valid = 1'b1; in_pix = IW'(p); in_sample = 8'(v);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic int base_of(int p);
    int t[$];
    int a, b, c;
    t = hist[p];
    t.rsort();
    a = (t.size() > 0) ? t[0] : 0;
    b = (t.size() > 1) ? t[1] : 0;
    c = (t.size() > 2) ? t[2] : 0;
    return (2 * a + b + c + 2) >> 2;
  endfunction

  function automatic int pat(int w, int p, int fr);
    case (w)
      0: return (p * 37 + fr * 53 + 11) % 256;
      1: begin
        if (p == 0) return 200;                       // R4 all equal
        if (p == 1) return (fr < 2) ? 250 : 10;       // R4 250,250,10 -> 190
        return (p * fr * 7 + 3) % 256;
      end
      default: begin
        if (p == 7) return 255;                       // R3 full scale
        return (p % 2 == 0) ? 0 : fr + 1;             // R8 small after large
      end
    endcase
  endfunction

  function automatic string tag_of(int w, int p);
    case (w)
      0: return (p == 3) ? "R5" : (p == 0) ? "R1" : "R2";
      1: return (p <= 1) ? "R4" : (p == 5) ? "R5" : "R7";
      default: return (p == 7) ? "R3" : "R8";
    endcase
  endfunction

  task automatic run_window(int w);
    for (int fr = 0; fr < FR; fr++) begin
      for (int p = 0; p < NPIX; p++) begin
        put(p, pat(w, p, fr));
        if (w == 0 && fr == 1 && p == 3) begin        // R5 back-to-back
          put(3, 250); put(3, 251); put(3, 252);
        end
        if (w == 1 && fr == 2 && p == 5) begin        // R5 back-to-back
          put(5, 9); put(5, 9); put(5, 240);
        end
        if (w == 1 && fr == 0 && p == 2) idle(1);
      end
    end
    for (int p = 0; p < NPIX; p++) begin
      exp_idx.push_back(p);
      exp_base.push_back(base_of(p));
      exp_req.push_back(tag_of(w, p));
      hist[p].delete();
    end
    // R7: readout cycles carry large junk that must not land
    for (int i = 0; i < NPIX; i++) junk((i * 3) % NPIX, 255 - i);
    idle(4);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n === 1'b1 && !done && out_valid === 1'b1) begin
      if (exp_idx.size() == 0) begin
        check(1'b0, "R9", int'(out_idx), -1);
      end else begin
        int ei, eb;
        string er;
        ei = exp_idx.pop_front();
        eb = exp_base.pop_front();
        er = exp_req.pop_front();
        check(int'(out_idx) == ei, "R6", int'(out_idx), ei);
        check(int'(out_base) == eb, er, int'(out_base), eb);
        if (ei != 0) check(last_out_cyc == cyc - 1, "R6", cyc - last_out_cyc, 1);
      end
      last_out_cyc = cyc;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_pix = '0; in_sample = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: junk during the clearing sweep must be ignored
    for (int i = 0; i < NPIX; i++) junk(i, 254);
    check(out_valid == 1'b0, "R9", int'(out_valid), 0);
    idle(6);
    run_window(0);
    run_window(1);
    run_window(2);
    idle(NPIX + 10);
    check(exp_idx.size() == 0, "R6", exp_idx.size(), 0);
    check(out_valid == 1'b0, "R9", int'(out_valid), 0);
    done = 1'b1;
    report();
  end
endmodule